// File: doc/BRIEF.md
# Glitch-Rejecting Input Qualifier

This block cleans up one asynchronous control line, such as a high-side drive command, a low-side drive command or a shutdown request, before the rest of a gate-drive controller acts on it. The raw line is first brought into the clock domain by a chain of flops. A new level is then accepted only once it has been seen without interruption for a set number of clock cycles. A spike shorter than that count never reaches the output, whichever way it points.

Rising and falling changes wait for the same number of cycles. A pulse that is long enough to pass therefore comes out with the same width, in cycles, that it had at the input, only shifted in time. The qualification count is a parameter. One design serves the drive inputs, with a long count of about 150 ns worth of cycles, and the shutdown input, with a short count of about 30 ns worth. Reset forces the output to its inactive low level.

Top module: `gf_glitch_filter`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it rises, `filt_out` is 0 whatever `raw_in` does. The synchroniser is cleared to 0 as well.
- R2: A high-going pulse on `raw_in` that lasts fewer than `FILT_CYCLES` clock cycles, on a line whose output is low, leaves `filt_out` at 0.
- R3: A low-going pulse on `raw_in` that lasts fewer than `FILT_CYCLES` clock cycles, on a line whose output is high, leaves `filt_out` at 1.
- R4: When `raw_in` takes a level different from `filt_out` and holds it for at least `FILT_CYCLES` cycles, `filt_out` takes that level exactly `SYNC_STAGES + FILT_CYCLES - 1` rising edges after the edge that first samples the new level.
- R5: Rising and falling changes have the same delay. An input pulse of W >= `FILT_CYCLES` cycles therefore gives an output pulse of exactly W cycles.
- R6: A run of disagreement that is broken by even one cycle of agreement restarts the count. Two runs of `FILT_CYCLES - 1` cycles separated by one cycle of the old level do not change the output.
- R7: Two successive changes of `filt_out` are at least `FILT_CYCLES` cycles apart.
- R8: `filt_out` changes only to the level that the synchronised input held in the cycle before the change. While the synchronised input equals the output, the output stays steady.
- R9: `filt_out` comes straight from a register and is never unknown once reset has been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 1 | Asynchronous raw control level to be qualified |
| filt_out | output | 1 | Qualified, registered control level (low when inactive) |

## Verification
The bench drives short high-going and low-going spikes, one cycle shorter than the count, and shows that neither moves the output. It also drives a pulse of exactly the count length and a long pulse. Their output edges must appear at the predicted cycle and with the input's width, which separates a correct equal delay from an off-by-one or an asymmetric delay. Two near-qualifying runs split by one cycle of the old level show that the counter restarts rather than accumulates. A burst of one-cycle toggles and a reset applied while the output is high cover the remaining corners.

// File: rtl/gf_pkg.sv
package gf_pkg;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } level_e;

  // Counter width able to hold 0 .. n-1 (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gf_qualify.sv
module gf_qualify #(
  parameter int unsigned FILT_CYCLES = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  output logic level
);
  import gf_pkg::*;

  localparam int unsigned CW = cnt_width(FILT_CYCLES);

  level_e state_q;
  logic   differ;

  assign differ = (sample != logic'(state_q));

  generate
    if (FILT_CYCLES <= 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst)         state_q <= LVL_LOW;
        else if (differ) state_q <= level_e'(sample);
      end
    end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q   <= '0;
          state_q <= LVL_LOW;
        end else if (!differ) begin
          cnt_q   <= '0;
        end else if (cnt_q == LAST) begin
          cnt_q   <= '0;
          state_q <= level_e'(sample);
        end else begin
          cnt_q   <= cnt_q + 1'b1;
        end
      end
    end
  endgenerate

  assign level = logic'(state_q);

endmodule

// File: rtl/gf_glitch_filter.sv
module gf_glitch_filter #(
  parameter int unsigned FILT_CYCLES = 15,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic filt_out
);

  logic synced;

  gf_sync #(
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk      (clk),
    .rst      (rst),
    .async_in (raw_in),
    .sync_out (synced)
  );

  gf_qualify #(
    .FILT_CYCLES (FILT_CYCLES)
  ) qual_i (
    .clk    (clk),
    .rst    (rst),
    .sample (synced),
    .level  (filt_out)
  );

endmodule

// File: rtl/gf_glitch_filter_chk.sv
module gf_glitch_filter_chk #(
  parameter int unsigned FILT_CYCLES = 15,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic raw_in,
  input logic filt_out
);

  localparam int unsigned SW = $clog2(FILT_CYCLES + 2);
  localparam logic [SW-1:0] SAT = SW'(FILT_CYCLES);

  logic [SYNC_STAGES-1:0] dly_q;
  logic                   dly_prev_q;
  logic                   prev_out_q;
  logic                   rst_q;
  logic [SW-1:0]          since_q;
  logic                   dly_last;
  logic                   chg;

  assign dly_last = dly_q[SYNC_STAGES-1];
  assign chg      = (filt_out != prev_out_q);

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      dly_q      <= '0;
      dly_prev_q <= 1'b0;
      prev_out_q <= 1'b0;
      since_q    <= SAT;
    end else begin
      dly_q      <= SYNC_STAGES'({dly_q, raw_in});
      dly_prev_q <= dly_last;
      prev_out_q <= filt_out;
      if (chg)                since_q <= SW'(1);
      else if (since_q < SAT) since_q <= since_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_LOW: assert (filt_out == 1'b0); // R1
    end
  end

  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (rst)
    chg |-> (since_q >= SAT)); // R7

  AST_TAKES_SYNCED_LEVEL: assert property (@(posedge clk) disable iff (rst)
    chg |-> (filt_out == dly_prev_q)); // R8

  AST_HOLD_WHEN_AGREED: assert property (@(posedge clk) disable iff (rst)
    (dly_last == filt_out) |=> $stable(filt_out)); // R8

  AST_NEVER_UNKNOWN: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(filt_out)); // R9

endmodule

bind gf_glitch_filter gf_glitch_filter_chk #(
  .FILT_CYCLES (FILT_CYCLES),
  .SYNC_STAGES (SYNC_STAGES)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .raw_in   (raw_in),
  .filt_out (filt_out)
);

// File: tb/gf_glitch_filter_tb_top.sv
`timescale 1ns/1ps
module gf_glitch_filter_tb_top;

  localparam int N = 15;
  localparam int S = 2;

  typedef struct {
    int   cyc;
    logic lvl;
    int   width;
  } ev_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw_in = 1'b0;
  logic filt_out;

  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  ev_t  sb_q[$];
  logic model_out = 1'b0;
  int   rise_in_c = 0;
  int   rise_out_c = 0;
  logic last_seen = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gf_glitch_filter #(
    .FILT_CYCLES (N),
    .SYNC_STAGES (S)
  ) dut_i (
    .clk      (clk),
    .rst      (rst),
    .raw_in   (raw_in),
    .filt_out (filt_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: called at a falling edge; holds raw_in at v for len clock edges.
  task automatic drive_seg(input logic v, input int len);
    int c;
    ev_t e;
    c = cyc;
    raw_in = v;
    if (v != model_out && len >= N) begin
      e.cyc = c + S + N;
      e.lvl = v;
      e.width = 0;
      if (v) rise_in_c = c;
      else   e.width = c - rise_in_c;
      sb_q.push_back(e);
      model_out = v;
    end
    repeat (len) @(negedge clk);
  endtask

  // Monitor: compares every output change against the scoreboard.
  always @(negedge clk) begin
    if (rst) begin
      last_seen = filt_out;
    end else if (filt_out !== last_seen) begin
      if (sb_q.size() == 0) begin
        check("R8 unexpected output change", 1, 0);
      end else begin
        ev_t e;
        e = sb_q.pop_front();
        check("R4 change cycle", cyc, e.cyc);
        check("R8 new level", int'(filt_out), int'(e.lvl));
        if (filt_out) rise_out_c = cyc;
        else check("R5 output width", cyc - rise_out_c, e.width);
      end
      last_seen = filt_out;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    raw_in = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 output in reset", int'(filt_out), 0);
    raw_in = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1 output after release", int'(filt_out), 0);
    repeat (10) @(negedge clk);

    // R2: high spike one cycle short
    drive_seg(1'b1, N - 1);
    drive_seg(1'b0, 30);
    check("R2 high spike rejected", int'(filt_out), 0);

    // R4/R5: pulse of exactly N, then a long pulse
    drive_seg(1'b1, N);
    drive_seg(1'b0, 40);
    drive_seg(1'b1, 40);
    drive_seg(1'b0, 40);

    // R3: low spike on a high line
    drive_seg(1'b1, 40);
    drive_seg(1'b0, N - 1);
    drive_seg(1'b1, 30);
    check("R3 low spike rejected", int'(filt_out), 1);

    // R6: two near-qualifying runs split by one agreeing cycle
    drive_seg(1'b0, N - 1);
    drive_seg(1'b1, 1);
    drive_seg(1'b0, N - 1);
    drive_seg(1'b1, 30);
    check("R6 count restarts", int'(filt_out), 1);
    drive_seg(1'b0, 40);

    // R2: burst of one-cycle toggles
    for (int i = 0; i < 6; i++) begin
      drive_seg(1'b1, 1);
      drive_seg(1'b0, 1);
    end
    drive_seg(1'b0, 30);
    check("R2 toggle burst rejected", int'(filt_out), 0);

    // R1: reset while output high
    drive_seg(1'b1, 40);
    check("R4 high before reset", int'(filt_out), 1);
    rst = 1'b1;
    raw_in = 1'b0;
    model_out = 1'b0;
    @(negedge clk);
    check("R1 reset clears high output", int'(filt_out), 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    check("R1 stays low after reset", int'(filt_out), 0);

    check("R4 scoreboard drained", sb_q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule